// File: doc/BRIEF.md
# Filtered Performance Event Counter Bank

This block holds four general-purpose event counters, each 48 bits wide. Every cycle the core presents one 4-bit occurrence count for each of four event sources, together with the current privilege level. Each counter picks one source through its configuration register. A filter in front of the counter decides whether anything is added that cycle, and how much. The filter looks at the privilege level, compares the count against an 8-bit threshold, and can invert that comparison or keep only its rising edge.

Software reaches the counters and their configuration registers through a single write port and a combinational read port. A counter that carries out of its top bit sets a sticky overflow flag. The flag stays set until software writes that counter.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset, all counters, configuration registers and overflow flags read as zero.
- R2: A counter may count only when its kernel enable (config bit 9) is set and the privilege level is 0, or when its user enable (config bit 8) is set and the level is 1, 2 or 3. On any other cycle it adds nothing.
- R3: With threshold (config bits 7:0) equal to zero, an allowed cycle adds the selected source's raw 4-bit count, and the invert and edge bits have no effect.
- R4: With a nonzero threshold and invert and edge clear, an allowed cycle adds exactly 1 when the count is at least the threshold, and 0 otherwise.
- R5: With a nonzero threshold and the invert bit (config bit 10) set, an allowed cycle adds 1 exactly when the count is below the threshold.
- R6: With a nonzero threshold and the edge bit (config bit 11) set, the counter adds 1 only when the qualified condition is met and was not met on the previous allowed cycle. A cycle that privilege blocks leaves the stored previous condition unchanged. Clearing both enables clears it.
- R7: Config bits 13:12 select which of the four sources feeds the counter. Source k is taken from evt_occ[4k+3:4k].
- R8: A carry out of bit 47 sets that counter's overflow flag. The flag stays set until that counter is written, and the write clears it.
- R9: When software writes a counter in a cycle where the filter would also add to it, the counter takes the written value.
- R10: addr[2]=0 selects counter addr[1:0]; addr[2]=1 selects that counter's configuration register. A write to a configuration register stores wdata[13:0], and reading it returns that value zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_lvl | input | 2 | Current privilege level, 0 being the kernel level |
| evt_occ | input | 16 | Four 4-bit per-cycle occurrence counts, source k at bits 4k+3:4k |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | 3 | Register select: bit 2 picks config or counter, bits 1:0 the counter |
| wdata | input | 48 | Write data |
| rdata | output | 48 | Read data for the register at addr, combinational |
| ovf | output | 4 | Sticky overflow flag of each counter |

## Verification
Two things can land on the same counter in one cycle: a software write, and an increment from the filter, which may also carry out of bit 47. The directed part writes a counter while its source is nonzero and checks that the written value wins. It also wraps a counter that is close to the top and checks that the flag stays set until the next write clears it. The random part issues writes on about one cycle in eight, with counter values biased toward the wrap point, alongside random counts, privilege levels and configurations. After every cycle the bench compares the read port and all four overflow flags against its own model.

// File: rtl/evt_counter_bank.sv
module evt_counter_bank #(
  parameter int NUM_CTR = 4,
  parameter int NUM_EVT = 4,
  parameter int OCC_W   = 4,
  parameter int THR_W   = 8,
  parameter int CNT_W   = 48
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               priv_lvl,
  input  logic [NUM_EVT*OCC_W-1:0] evt_occ,
  input  logic                     wr_en,
  input  logic [$clog2(NUM_CTR):0] addr,
  input  logic [CNT_W-1:0]         wdata,
  output logic [CNT_W-1:0]         rdata,
  output logic [NUM_CTR-1:0]       ovf
);
  localparam int IDX_W = $clog2(NUM_CTR);
  localparam int SEL_W = $clog2(NUM_EVT);
  localparam int F_USR = THR_W;
  localparam int F_KRN = THR_W + 1;
  localparam int F_INV = THR_W + 2;
  localparam int F_EDG = THR_W + 3;
  localparam int F_SEL = THR_W + 4;
  localparam int CFG_W = THR_W + 4 + SEL_W;

  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CTR-1:0][CFG_W-1:0] cfg_all;

  wire             is_cfg = addr[IDX_W];
  wire [IDX_W-1:0] idx    = addr[IDX_W-1:0];

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    logic [CNT_W-1:0] cnt_r;
    logic [CFG_W-1:0] cfg_r;
    logic             prev_r;
    logic             ovf_r;

    wire              hit     = wr_en && (idx == IDX_W'(g));
    wire              cnt_wr  = hit && !is_cfg;
    wire              cfg_wr  = hit && is_cfg;
    wire [THR_W-1:0]  thr     = cfg_r[THR_W-1:0];
    wire [SEL_W-1:0]  sel     = cfg_r[F_SEL +: SEL_W];
    wire [OCC_W-1:0]  occ     = evt_occ[sel*OCC_W +: OCC_W];
    wire              usr     = cfg_r[F_USR];
    wire              krn     = cfg_r[F_KRN];
    wire              allow   = (priv_lvl == 2'd0) ? krn : usr;
    wire              thr_on  = |thr;
    wire              cond    = (THR_W'(occ) >= thr) ^ cfg_r[F_INV];
    wire              pulse   = cfg_r[F_EDG] ? (cond && !prev_r) : cond;
    wire [OCC_W-1:0]  step    = !allow ? '0 : (thr_on ? OCC_W'(pulse) : occ);
    wire [CNT_W:0]    sum     = {1'b0, cnt_r} + (CNT_W+1)'(step);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_r  <= '0;
        cfg_r  <= '0;
        prev_r <= 1'b0;
        ovf_r  <= 1'b0;
      end else begin
        if (cfg_wr) cfg_r <= wdata[CFG_W-1:0];
        if (cnt_wr) begin
          cnt_r <= wdata;
          ovf_r <= 1'b0;
        end else begin
          cnt_r <= sum[CNT_W-1:0];
          if (sum[CNT_W]) ovf_r <= 1'b1;
        end
        if (!(usr || krn) || !thr_on) prev_r <= 1'b0;
        else if (allow)               prev_r <= cond;
      end
    end

    assign cnt_all[g] = cnt_r;
    assign cfg_all[g] = cfg_r;
    assign ovf[g]     = ovf_r;
  end

  assign rdata = is_cfg ? CNT_W'(cfg_all[idx]) : cnt_all[idx];
endmodule

// File: rtl/evt_counter_bank_chk.sv
module evt_counter_bank_chk #(
  parameter int NUM_CTR = 4,
  parameter int THR_W   = 8,
  parameter int CNT_W   = 48,
  parameter int CFG_W   = 14
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en,
  input logic [$clog2(NUM_CTR):0]      addr,
  input logic [NUM_CTR-1:0]            ovf,
  input logic [NUM_CTR-1:0][CNT_W-1:0] cnt_all,
  input logic [NUM_CTR-1:0][CFG_W-1:0] cfg_all
);
  localparam int IDX_W = $clog2(NUM_CTR);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    wire wr_cnt = wr_en && !addr[IDX_W] && (addr[IDX_W-1:0] == IDX_W'(i));
    wire thr_on = |cfg_all[i][THR_W-1:0];
    wire en_any = cfg_all[i][THR_W] || cfg_all[i][THR_W+1];

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf[i] && !wr_cnt) |=> ovf[i]);

    assert_wr_clears_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> !ovf[i]);

    assert_idle_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_any && !wr_cnt) |=> (cnt_all[i] == $past(cnt_all[i])));

    assert_thr_step_max_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_on && !wr_cnt) |=> ((cnt_all[i] - $past(cnt_all[i])) <= CNT_W'(1)));

    assert_raw_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!thr_on && !wr_cnt) |=> ((cnt_all[i] - $past(cnt_all[i])) <= CNT_W'(15)));
  end
endmodule

bind evt_counter_bank evt_counter_bank_chk #(
  .NUM_CTR(NUM_CTR), .THR_W(THR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .ovf(ovf),
  .cnt_all(cnt_all), .cfg_all(cfg_all)
);

// File: tb/evt_counter_bank_tb_top.sv
`timescale 1ns/100ps
module evt_counter_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv_lvl = '0;
  logic [15:0] evt_occ = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [47:0] wdata = '0;
  logic [47:0] rdata;
  logic [3:0]  ovf;

  int n_chk = 0, n_fail = 0;

  logic [47:0] m_cnt [4];
  logic [13:0] m_cfg [4];
  logic        m_prev [4];
  logic        m_ovf [4];

  always #2.5 clk = ~clk;

  evt_counter_bank dut_i (.clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .evt_occ(evt_occ),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .ovf(ovf));

  function automatic logic [13:0] mk(input logic [1:0] sel, input logic edg, input logic inv,
                                     input logic krn, input logic usr, input logic [7:0] thr);
    return {sel, edg, inv, krn, usr, thr};
  endfunction

  task automatic check(input string tag, input logic [47:0] got, input logic [47:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < 4; i++) begin
      logic [7:0] thr = m_cfg[i][7:0];
      logic usr = m_cfg[i][8], krn = m_cfg[i][9], inv = m_cfg[i][10], edg = m_cfg[i][11];
      logic [3:0] occ = evt_occ[m_cfg[i][13:12]*4 +: 4];
      logic allow = (priv_lvl == 0) ? krn : usr;
      logic met = ({4'b0, occ} >= thr) != inv;
      logic [48:0] nxt;
      logic [3:0] add = 0;
      if (allow) begin
        if (thr == 0) add = occ;
        else if (edg) add = {3'b0, met && !m_prev[i]};
        else add = {3'b0, met};
      end
      if ((!usr && !krn) || thr == 0) m_prev[i] = 1'b0;
      else if (allow) m_prev[i] = met;
      if (wr_en && addr == 3'(i)) begin
        m_cnt[i] = wdata;
        m_ovf[i] = 1'b0;
      end else begin
        nxt = {1'b0, m_cnt[i]} + 49'(add);
        m_cnt[i] = nxt[47:0];
        if (nxt[48]) m_ovf[i] = 1'b1;
      end
      if (wr_en && addr == 3'(4 + i)) m_cfg[i] = wdata[13:0];
    end
  endtask

  task automatic tick(input logic [15:0] occ, input logic [1:0] pl, input logic we,
                      input logic [2:0] a, input logic [47:0] d);
    evt_occ = occ; priv_lvl = pl; wr_en = we; addr = a; wdata = d;
    model_step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [47:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [47:0] v;
    void'($urandom(32'd7031));
    for (int i = 0; i < 4; i++) begin
      m_cnt[i] = 0; m_cfg[i] = 0; m_prev[i] = 0; m_ovf[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 8; a++) begin
      peek(3'(a), v);
      check("R1 reset register", v, 48'h0);
    end
    check("R1 reset ovf", {44'h0, ovf}, 48'h0);

    tick(0, 0, 1, 3'd5, 48'(mk(1, 0, 1, 1, 0, 8'h2A)));
    peek(3'd5, v);
    check("R10 config readback", v, 48'(mk(1, 0, 1, 1, 0, 8'h2A)));

    tick(0, 3, 1, 3'd4, 48'(mk(0, 1, 1, 1, 1, 0)));
    repeat (3) tick(16'h0005, 3, 0, 0, 0);
    peek(3'd0, v);
    check("R3 raw count, invert and edge ignored", v, 48'd15);

    tick(0, 3, 1, 3'd4, 48'(mk(0, 0, 0, 0, 1, 0)));
    tick(0, 3, 1, 3'd0, 48'd0);
    repeat (2) tick(16'h0003, 0, 0, 0, 0);
    peek(3'd0, v);
    check("R2 user-only blocked at level 0", v, 48'd0);
    tick(16'h0003, 2, 0, 0, 0);
    peek(3'd0, v);
    check("R2 user-only counts at level 2", v, 48'd3);
    tick(0, 3, 1, 3'd4, 48'(mk(0, 0, 0, 1, 0, 0)));
    tick(16'h0003, 1, 0, 0, 0);
    tick(16'h0003, 0, 0, 0, 0);
    peek(3'd0, v);
    check("R2 kernel-only counts only at level 0", v, 48'd6);

    tick(0, 3, 1, 3'd4, 48'(mk(0, 1, 0, 1, 1, 2)));
    tick(0, 3, 1, 3'd0, 48'd0);
    tick(16'h0000, 3, 0, 0, 0);
    tick(16'h0003, 3, 0, 0, 0);
    tick(16'h0003, 3, 0, 0, 0);
    tick(16'h0000, 3, 0, 0, 0);
    tick(16'h0003, 3, 0, 0, 0);
    peek(3'd0, v);
    check("R6 rising edges counted", v, 48'd2);
    tick(16'h0003, 3, 1, 3'd0, 48'd0);
    tick(16'h0003, 3, 1, 3'd4, 48'(mk(0, 1, 0, 0, 1, 2)));
    tick(16'h0000, 0, 0, 0, 0);
    tick(16'h0003, 3, 0, 0, 0);
    peek(3'd0, v);
    check("R6 edge state held across blocked cycle", v, 48'd0);
    tick(16'h0003, 3, 1, 3'd4, 48'd0);
    tick(16'h0003, 3, 0, 0, 0);
    tick(16'h0000, 3, 1, 3'd4, 48'(mk(0, 1, 0, 0, 1, 2)));
    tick(16'h0003, 3, 0, 0, 0);
    peek(3'd0, v);
    check("R6 edge state cleared by disable", v, 48'd1);

    tick(0, 3, 1, 3'd4, 48'(mk(0, 0, 1, 1, 1, 2)));
    tick(0, 3, 1, 3'd0, 48'd0);
    tick(16'h0000, 3, 0, 0, 0);
    tick(16'h0001, 3, 0, 0, 0);
    tick(16'h0002, 3, 0, 0, 0);
    tick(16'h0003, 3, 0, 0, 0);
    peek(3'd0, v);
    check("R5 inverted threshold", v, 48'd2);

    tick(0, 3, 1, 3'd4, 48'(mk(2, 0, 0, 1, 1, 0)));
    tick(0, 3, 1, 3'd0, 48'd0);
    tick(16'h0701, 3, 0, 0, 0);
    peek(3'd0, v);
    check("R7 source 2 selected", v, 48'd7);

    tick(0, 3, 1, 3'd0, 48'hFFFF_FFFF_FFFD);
    tick(16'h0500, 3, 0, 0, 0);
    peek(3'd0, v);
    check("R8 wrapped value", v, 48'd2);
    check("R8 overflow set", {47'h0, ovf[0]}, 48'd1);
    tick(0, 3, 0, 0, 0);
    check("R8 overflow sticky", {47'h0, ovf[0]}, 48'd1);
    tick(0, 3, 1, 3'd0, 48'h10);
    check("R8 overflow cleared by write", {47'h0, ovf[0]}, 48'd0);

    tick(16'h0500, 3, 1, 3'd0, 48'd100);
    peek(3'd0, v);
    check("R9 write wins over increment", v, 48'd100);

    for (int n = 0; n < 4000; n++) begin
      logic [2:0] a = 3'($urandom % 8);
      logic we = ($urandom % 8) == 0;
      logic [47:0] d;
      if (a[2]) d = 48'(mk(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                          1'($urandom), 8'($urandom % 6)));
      else if ($urandom % 2) d = 48'hFFFF_FFFF_FFF0 | 48'($urandom % 16);
      else d = {16'($urandom), 32'($urandom)};
      tick(16'($urandom), 2'($urandom), we, a, d);
      peek(3'($urandom % 8), v);
      check(addr[2] ? "R10 random config" : "R4 random counter", v,
            addr[2] ? 48'(m_cfg[addr[1:0]]) : m_cnt[addr[1:0]]);
      check("R8 random overflow flags", {44'h0, ovf},
            {44'h0, m_ovf[3], m_ovf[2], m_ovf[1], m_ovf[0]});
    end
    summary();
  end
endmodule